// File: doc/BRIEF.md
# Radix-5 Decimal Partial Product Generator

This block forms the two partial products that one multiplier digit contributes in a parallel decimal multiplier. The multiplicand is an N-digit BCD number X; the multiplier digit Y is one BCD digit. Y is split into an upper part YU in {0,1,2} and a signed lower part YL in {-2..2} with Y = 5·YU + YL. The upper product is 0, 5X or 10X, and the lower product is 0, ±X or ±2X.

No multiple needs a carry chain. The doubled multiplicand comes from writing every digit in a 5-2-1-1 weighted code and shifting the whole bit vector up by one place; the result then reads as 2X in 4-2-2-1 code. The quintupled multiplicand comes from writing every digit in 4-2-2-1 code and shifting up by three places; the result then reads as 5X in 5-2-1-1 code, and a per-digit converter turns it back to 4-2-2-1. All outputs are N+1 digits of 4-2-2-1 code. A negative lower product leaves as its bitwise inverse, which is its nine's complement, together with a flag. The reduction stage that follows adds that flag as a one at the least significant digit.

An optional output register gives one cycle of latency. Without it the block is purely combinational.

Top module: `dec5_pp_gen`

## Requirements
- R1: Y is recoded as 0→(0,0), 1→(0,+1), 2→(0,+2), 3→(1,-2), 4→(1,-1), 5→(1,0), 6→(1,+1), 7→(1,+2), 8→(2,-2), 9→(2,-1), where the pair is (YU, YL).
- R2: The upper output equals YU·5·X. It is read as N+1 digits of 4-2-2-1 code, digit i at bits [4i+3:4i] with bit weights 4,2,2,1 from bit 3 down to bit 0.
- R3: When YL ≥ 0 the lower output equals YL·X in the same code and the sign flag is 0. For Y equal to 0 or 5 the lower output is zero.
- R4: When YL < 0 the sign flag is 1. Every digit of the lower output then equals 9 minus the matching digit of |YL|·X.
- R5: The upper output, plus the lower output, plus the sign flag equals X·Y modulo 10^(N+1).
- R6: With the output register enabled, outputs reflect the inputs of the previous clock edge and stay put between edges. While reset (active low, asynchronous) is held, all outputs are zero.
- R7: A non-decimal Y code (10 to 15) gives zero on both outputs and a clear sign flag.
- R8: The extreme case X made of all nines with Y = 9 gives the exact product. This covers the largest growth into the extra digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_bcd | input | 4*NDIG | Multiplicand, BCD, digit i at bits [4i+3:4i] |
| y_bcd | input | 4 | Multiplier digit, BCD |
| pp_up | output | 4*(NDIG+1) | Upper partial product (0, 5X, 10X), 4-2-2-1 code |
| pp_lo | output | 4*(NDIG+1) | Lower partial product (0, X, 2X or their nine's complement), 4-2-2-1 code |
| lo_neg | output | 1 | Lower product is negative; add one at the least significant digit |

## Verification
The bench builds the block with NDIG = 4 and the output register on. This keeps every value within a 64-bit integer, so the bench can decode the outputs back to numbers and compare them with X·Y computed directly. With four digits, the all-nines multiplicand drives both the carry bit of the doubling shift and the three spilled bits of the quintupling shift into the extra top digit. The bench also checks that new inputs leave the outputs unchanged until the next edge. All sixteen Y codes are swept over directed and random multiplicands.

// File: rtl/dec5_pkg.sv
package dec5_pkg;

    // Recoded multiplier digit: Y = 5*up_sel + (lo_neg ? -lo_mag : lo_mag)
    typedef struct packed {
        logic [1:0] up_sel;
        logic       lo_neg;
        logic [1:0] lo_mag;
    } ydig_t;

    // BCD digit to 5-2-1-1 code (weights b3=5, b2=2, b1=1, b0=1)
    function automatic logic [3:0] bcd_to_c5211(input logic [3:0] d);
        logic [3:0] r;
        case (d)
            4'd0: r = 4'b0000;
            4'd1: r = 4'b0001;
            4'd2: r = 4'b0011;
            4'd3: r = 4'b0101;
            4'd4: r = 4'b0111;
            4'd5: r = 4'b1000;
            4'd6: r = 4'b1001;
            4'd7: r = 4'b1011;
            4'd8: r = 4'b1101;
            4'd9: r = 4'b1111;
            default: r = 4'b0000;
        endcase
        return r;
    endfunction

    // BCD digit to 4-2-2-1 code (weights b3=4, b2=2, b1=2, b0=1)
    function automatic logic [3:0] bcd_to_c4221(input logic [3:0] d);
        logic [3:0] r;
        case (d)
            4'd0: r = 4'b0000;
            4'd1: r = 4'b0001;
            4'd2: r = 4'b0010;
            4'd3: r = 4'b0011;
            4'd4: r = 4'b1000;
            4'd5: r = 4'b1001;
            4'd6: r = 4'b1010;
            4'd7: r = 4'b1011;
            4'd8: r = 4'b1110;
            4'd9: r = 4'b1111;
            default: r = 4'b0000;
        endcase
        return r;
    endfunction

    // Any 5-2-1-1 pattern to canonical 4-2-2-1 code
    function automatic logic [3:0] c5211_to_c4221(input logic [3:0] c);
        logic [3:0] v;
        v = (c[3] ? 4'd5 : 4'd0) + (c[2] ? 4'd2 : 4'd0)
          + {3'b000, c[1]} + {3'b000, c[0]};
        return bcd_to_c4221(v);
    endfunction

endpackage

// File: rtl/dec5_ydigit_recode.sv
module dec5_ydigit_recode
    import dec5_pkg::*;
(
    input  logic [3:0] y_bcd,
    output ydig_t      code
);
    always_comb begin
        code = '0;
        case (y_bcd)
            4'd0: code = '{up_sel: 2'd0, lo_neg: 1'b0, lo_mag: 2'd0};
            4'd1: code = '{up_sel: 2'd0, lo_neg: 1'b0, lo_mag: 2'd1};
            4'd2: code = '{up_sel: 2'd0, lo_neg: 1'b0, lo_mag: 2'd2};
            4'd3: code = '{up_sel: 2'd1, lo_neg: 1'b1, lo_mag: 2'd2};
            4'd4: code = '{up_sel: 2'd1, lo_neg: 1'b1, lo_mag: 2'd1};
            4'd5: code = '{up_sel: 2'd1, lo_neg: 1'b0, lo_mag: 2'd0};
            4'd6: code = '{up_sel: 2'd1, lo_neg: 1'b0, lo_mag: 2'd1};
            4'd7: code = '{up_sel: 2'd1, lo_neg: 1'b0, lo_mag: 2'd2};
            4'd8: code = '{up_sel: 2'd2, lo_neg: 1'b1, lo_mag: 2'd2};
            4'd9: code = '{up_sel: 2'd2, lo_neg: 1'b1, lo_mag: 2'd1};
            default: code = '0;
        endcase
    end
endmodule

// File: rtl/dec5_multiples.sv
module dec5_multiples
    import dec5_pkg::*;
#(
    parameter int NDIG = 16
) (
    input  logic [4*NDIG-1:0]     x_bcd,
    output logic [4*(NDIG+1)-1:0] x1_o,
    output logic [4*(NDIG+1)-1:0] x2_o,
    output logic [4*(NDIG+1)-1:0] x5_o,
    output logic [4*(NDIG+1)-1:0] x10_o
);
    localparam int WIN  = 4 * NDIG;
    localparam int WOUT = 4 * (NDIG + 1);

    logic [WIN-1:0]  x_5211;
    logic [WIN-1:0]  x_4221;
    logic [WOUT-1:0] x5_raw;

    // Per-digit code conversion of the multiplicand
    for (genvar i = 0; i < NDIG; i++) begin : g_in
        always_comb begin
            x_5211[4*i +: 4] = bcd_to_c5211(x_bcd[4*i +: 4]);
            x_4221[4*i +: 4] = bcd_to_c4221(x_bcd[4*i +: 4]);
        end
    end

    // x2: 5211 vector shifted left by one bit reads as 4221
    assign x2_o   = {3'b000, x_5211, 1'b0};
    // x5: 4221 vector shifted left by three bits reads as 5211
    assign x5_raw = {1'b0, x_4221, 3'b000};
    assign x1_o   = {4'b0000, x_4221};
    assign x10_o  = {x_4221, 4'b0000};

    // Bring x5 back to the common 4221 output code
    for (genvar j = 0; j < NDIG + 1; j++) begin : g_x5
        assign x5_o[4*j +: 4] = c5211_to_c4221(x5_raw[4*j +: 4]);
    end
endmodule

// File: rtl/dec5_pp_select.sv
module dec5_pp_select
    import dec5_pkg::*;
#(
    parameter int NDIG = 16
) (
    input  ydig_t                 code,
    input  logic [4*(NDIG+1)-1:0] x1_i,
    input  logic [4*(NDIG+1)-1:0] x2_i,
    input  logic [4*(NDIG+1)-1:0] x5_i,
    input  logic [4*(NDIG+1)-1:0] x10_i,
    output logic [4*(NDIG+1)-1:0] up_o,
    output logic [4*(NDIG+1)-1:0] lo_o,
    output logic                  neg_o
);
    localparam int W = 4 * (NDIG + 1);

    logic [W-1:0] lo_mag_v;

    always_comb begin
        case (code.up_sel)
            2'd1:    up_o = x5_i;
            2'd2:    up_o = x10_i;
            default: up_o = '0;
        endcase
        case (code.lo_mag)
            2'd1:    lo_mag_v = x1_i;
            2'd2:    lo_mag_v = x2_i;
            default: lo_mag_v = '0;
        endcase
        // 4221 weights sum to 9: inversion is the nine's complement
        lo_o  = code.lo_neg ? ~lo_mag_v : lo_mag_v;
        neg_o = code.lo_neg;
    end
endmodule

// File: rtl/dec5_pp_gen.sv
module dec5_pp_gen
    import dec5_pkg::*;
#(
    parameter int NDIG    = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [4*NDIG-1:0]     x_bcd,
    input  logic [3:0]            y_bcd,
    output logic [4*(NDIG+1)-1:0] pp_up,
    output logic [4*(NDIG+1)-1:0] pp_lo,
    output logic                  lo_neg
);
    localparam int W = 4 * (NDIG + 1);

    typedef struct packed {
        logic [W-1:0] up;
        logic [W-1:0] lo;
        logic         neg;
    } pp_t;

    ydig_t        ycode;
    logic [W-1:0] m1, m2, m5, m10;
    logic [W-1:0] sel_up, sel_lo;
    logic         sel_neg;
    pp_t          pp_d, pp_q;

    dec5_ydigit_recode u_recode (
        .y_bcd (y_bcd),
        .code  (ycode)
    );

    dec5_multiples #(.NDIG(NDIG)) u_mult (
        .x_bcd (x_bcd),
        .x1_o  (m1),
        .x2_o  (m2),
        .x5_o  (m5),
        .x10_o (m10)
    );

    dec5_pp_select #(.NDIG(NDIG)) u_sel (
        .code  (ycode),
        .x1_i  (m1),
        .x2_i  (m2),
        .x5_i  (m5),
        .x10_i (m10),
        .up_o  (sel_up),
        .lo_o  (sel_lo),
        .neg_o (sel_neg)
    );

    always_comb begin
        pp_d     = '0;
        pp_d.up  = sel_up;
        pp_d.lo  = sel_lo;
        pp_d.neg = sel_neg;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pp_q <= '0;
            else        pp_q <= pp_d;
        end
    end else begin : g_comb
        assign pp_q = pp_d;
    end

    assign pp_up  = pp_q.up;
    assign pp_lo  = pp_q.lo;
    assign lo_neg = pp_q.neg;

    // R2
    up_zero_low_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_bcd <= 4'd2) |-> (pp_d.up == '0));
    // R1
    neg_only_for_3489_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pp_d.neg |-> (y_bcd == 4'd3 || y_bcd == 4'd4 || y_bcd == 4'd8 || y_bcd == 4'd9));
    // R3
    lo_zero_y05_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_bcd == 4'd0 || y_bcd == 4'd5) |-> (pp_d.lo == '0 && !pp_d.neg));
    // R7
    bad_digit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_bcd > 4'd9) |-> (pp_d.up == '0 && pp_d.lo == '0 && !pp_d.neg));
    // R8
    dbl_top_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m2[W-1:W-3] == 3'b000);
    // R4
    neg_lo_lsd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_bcd == 4'd3 || y_bcd == 4'd8) |-> (pp_d.lo[0] == 1'b1 && pp_d.neg));
endmodule

// File: tb/dec5_pp_gen_tb.sv
module dec5_pp_gen_tb;
    localparam int  NDIG   = 4;
    localparam int  W      = 4 * (NDIG + 1);
    localparam int  CLK_NS = 10;
    localparam longint MODV = 100000;

    typedef struct {
        longint xv;
        int     yv;
        longint up;
        longint lo;
        bit     neg;
    } item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4*NDIG-1:0] x_bcd = '0;
    logic [3:0]      y_bcd = '0;
    logic [W-1:0]    pp_up, pp_lo;
    logic            lo_neg;

    int    n_chk = 0;
    int    n_err = 0;
    item_t sb[$];
    item_t last_it;
    bit    have_last = 1'b0;
    bit    done = 1'b0;

    dec5_pp_gen #(.NDIG(NDIG), .REG_OUT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .x_bcd(x_bcd), .y_bcd(y_bcd),
        .pp_up(pp_up), .pp_lo(pp_lo), .lo_neg(lo_neg)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic longint dec4221(input logic [W-1:0] v);
        longint s = 0;
        longint p = 1;
        for (int i = 0; i < NDIG + 1; i++) begin
            s += p * (4*v[4*i+3] + 2*v[4*i+2] + 2*v[4*i+1] + v[4*i]);
            p *= 10;
        end
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: apply at negedge, push expectation, confirm outputs hold (R6)
    task automatic drive(input longint xv, input int yv);
        item_t it;
        int yu, yl, mag;
        longint t;
        @(negedge clk);
        t = xv;
        for (int i = 0; i < NDIG; i++) begin
            x_bcd[4*i +: 4] = 4'(t % 10);
            t /= 10;
        end
        y_bcd = 4'(yv);
        yu = 0; yl = 0;
        if (yv <= 9) begin
            yu = (yv + 2) / 5;
            yl = yv - 5 * yu;
        end
        mag = (yl < 0) ? -yl : yl;
        it.xv  = xv;
        it.yv  = yv;
        it.up  = 5 * yu * xv;
        it.neg = (yl < 0);
        it.lo  = it.neg ? (MODV - 1 - mag * xv) : (mag * xv);
        sb.push_back(it);
        #1;
        if (have_last) begin
            chk(dec4221(pp_up) == last_it.up, "R6 hold up", dec4221(pp_up), last_it.up);
            chk(lo_neg == last_it.neg, "R6 hold neg", lo_neg, last_it.neg);
        end
        last_it = it;
        have_last = 1'b1;
    endtask

    // Monitor: outputs appear one edge after the inputs
    always begin
        @(posedge clk);
        #1;
        if (rst_n && sb.size() > 0) begin
            item_t it;
            longint u, l, s;
            it = sb.pop_front();
            u = dec4221(pp_up);
            l = dec4221(pp_lo);
            chk(u == it.up, $sformatf("R2 up x=%0d y=%0d", it.xv, it.yv), u, it.up);
            if (it.neg)
                chk(l == it.lo, $sformatf("R4 lo-neg x=%0d y=%0d", it.xv, it.yv), l, it.lo);
            else
                chk(l == it.lo, $sformatf("R3 lo x=%0d y=%0d", it.xv, it.yv), l, it.lo);
            chk(lo_neg == it.neg, $sformatf("R1 sign y=%0d", it.yv), lo_neg, it.neg);
            if (it.yv <= 9) begin
                s = (u + l + lo_neg) % MODV;
                chk(s == it.xv * it.yv, $sformatf("R5 sum x=%0d y=%0d", it.xv, it.yv), s, it.xv * it.yv);
            end else begin
                chk(u == 0 && l == 0 && !lo_neg, $sformatf("R7 y=%0d", it.yv), u + l, 0);
            end
        end
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        longint xr;
        repeat (3) @(negedge clk);
        #1;
        chk(pp_up == '0 && pp_lo == '0 && lo_neg == 1'b0, "R6 reset", dec4221(pp_up), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: all nines, including Y = 9
        for (int y = 0; y < 16; y++) drive(9999, y);
        for (int y = 0; y < 10; y++) drive(0, y);
        for (int y = 0; y < 10; y++) drive(1, y);
        for (int y = 0; y < 10; y++) drive(5555, y);
        for (int y = 0; y < 10; y++) drive(9090, y);
        drive(9999, 9);
        for (int k = 0; k < 400; k++) begin
            xr = 0;
            for (int d = 0; d < NDIG; d++) xr = xr * 10 + ($urandom % 10);
            drive(xr, $urandom % 16);
        end
        @(negedge clk);
        @(negedge clk);
        chk(sb.size() == 0, "R6 drain", sb.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule